// File: doc/BRIEF.md
# 8-bit Accumulator ALU with Flag Update Mask

This block is the purely combinational arithmetic and logic unit of a small 8-bit accumulator machine. Each evaluation takes an accumulator-side operand, a second operand, a 4-bit operation code and the current negative, overflow, zero and carry flags. It returns a result byte, the new flag values and a per-flag write-enable mask. The register file around it stores the result and flags; those parts are not in this block.

Subtraction reuses the adder on the inverted operand with the incoming carry, so a set carry means no borrow. Compare uses the same path with the carry forced to one, updates only N, Z and C, and passes the accumulator through unchanged. Flags that an operation does not touch are copied from the input, and their mask bits are low.

Top module: `alu8_core`

## Requirements
- R1: With op code 0 (add), the result is (a + b + C) mod 256 and C becomes 1 exactly when the unsigned sum exceeds 255. N, V, Z and C are all written.
- R2: With op code 1 (subtract), the result is (a + ~b + C) mod 256 and C becomes the adder carry, so C is 1 when no borrow occurs. N, V, Z and C are all written.
- R3: For add, V is set when (a ^ res) & (b ^ res) has bit 7 set. For subtract, ~b takes the place of b. No other op code writes V.
- R4: With op code 2 (compare), the result equals a unchanged. C is 1 when a ≥ b unsigned, Z is 1 when a equals b, and N is bit 7 of (a − b). The incoming carry has no effect, and V keeps its input value.
- R5: Op codes 3, 4 and 5 give a AND b, a OR b and a XOR b. Only N and Z are written.
- R6: Op code 6 shifts a left, with bit 7 going to C and 0 entering bit 0. Op code 7 shifts a right, with bit 0 going to C and 0 entering bit 7. N, Z and C are written.
- R7: Op code 8 rotates a left, with the old C entering bit 0 and bit 7 going to C. Op code 9 rotates a right, with the old C entering bit 7 and bit 0 going to C. N, Z and C are written.
- R8: Op codes 10 and 11 give a + 1 and a − 1, wrapping at 8 bits. Only N and Z are written.
- R9: Op code 12 (pass) gives b as the result, for loads and transfers. Only N and Z are written.
- R10: Flag vectors use bit 3 = N, bit 2 = V, bit 1 = Z and bit 0 = C. Where flag_we_o has a 0, flags_o equals flags_i. Written N and Z follow bit 7 and zero-ness of the result, except for compare (R4).
- R11: Op codes 13 to 15 are no-ops: the result equals a, flag_we_o is 0 and flags_o equals flags_i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 8 | Accumulator-side operand |
| b_i | input | 8 | Second operand (memory or immediate value) |
| op_i | input | 4 | Operation code |
| flags_i | input | 4 | Current flags {N,V,Z,C} |
| res_o | output | 8 | Result byte |
| flags_o | output | 4 | Updated flags {N,V,Z,C} |
| flag_we_o | output | 4 | Per-flag write enable {N,V,Z,C} |

## Verification
The block holds no state, so any fault shows on the ports in the same evaluation as the stimulus that triggers it. A bad operand inversion or carry select shows at once as a wrong byte or a wrong carry on the signed and unsigned boundary values (0x7F/0x80, 0xFF/0x00). A wrong mask decode shows as a flag that changes against its input when it should keep it. The directed cases therefore preload flag inputs opposite to the values the operation would produce, so that a missing hold is always visible.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_CMP  = 4'd2,
    OP_AND  = 4'd3,
    OP_OR   = 4'd4,
    OP_XOR  = 4'd5,
    OP_SHL  = 4'd6,
    OP_SHR  = 4'd7,
    OP_ROL  = 4'd8,
    OP_ROR  = 4'd9,
    OP_INC  = 4'd10,
    OP_DEC  = 4'd11,
    OP_PASS = 4'd12
  } alu_op_e;

  localparam int FLAG_C = 0;
  localparam int FLAG_Z = 1;
  localparam int FLAG_V = 2;
  localparam int FLAG_N = 3;
  localparam int NFLAGS = 4;

  localparam logic [NFLAGS-1:0] WE_ALL  = 4'b1111;
  localparam logic [NFLAGS-1:0] WE_NZC  = 4'b1011;
  localparam logic [NFLAGS-1:0] WE_NZ   = 4'b1010;
  localparam logic [NFLAGS-1:0] WE_NONE = 4'b0000;
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  input  logic             sub_i,
  input  logic             cmp_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o,
  output logic             ovf_o
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] b_eff;
  logic             c_eff;

  assign b_eff = sub_i ? ~b_i : b_i;
  // compare is a subtract with no pending borrow
  assign c_eff = cmp_i ? 1'b1 : cin_i;
  assign {cout_o, sum_o} = {1'b0, a_i} + {1'b0, b_eff} + {{WIDTH{1'b0}}, c_eff};

  logic [WIDTH-1:0] sgn;
  assign sgn   = (a_i ^ sum_o) & (b_eff ^ sum_o);
  assign ovf_o = sgn[MSB];

  always_comb begin
    if (!sub_i && cout_o)
      a_r1_add_wrap: assert (sum_o <= a_i);
    if (ovf_o)
      a_r3_ovf_sign: assert (sum_o[MSB] != a_i[MSB]);
    if (cmp_i)
      a_r4_cmp_carry: assert (cout_o == (a_i >= b_i));
  end
endmodule

// File: rtl/alu8_shift.sv
module alu8_shift #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic             cin_i,
  input  logic             left_i,
  input  logic             rot_i,
  output logic [WIDTH-1:0] res_o,
  output logic             cout_o
);
  localparam int MSB = WIDTH - 1;

  logic fill;
  assign fill = rot_i ? cin_i : 1'b0;

  always_comb begin
    if (left_i) begin
      res_o  = {a_i[MSB-1:0], fill};
      cout_o = a_i[MSB];
    end else begin
      res_o  = {fill, a_i[MSB:1]};
      cout_o = a_i[0];
    end
  end

  always_comb begin
    if (left_i)
      a_r6_left_out: assert (cout_o == a_i[MSB] && res_o[0] == (rot_i & cin_i));
    else
      a_r6_right_out: assert (cout_o == a_i[0] && res_o[MSB] == (rot_i & cin_i));
  end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
  import alu8_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  alu_op_e          op_i,
  output logic [WIDTH-1:0] res_o
);
  localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

  always_comb begin
    unique case (op_i)
      OP_AND:  res_o = a_i & b_i;
      OP_OR:   res_o = a_i | b_i;
      OP_XOR:  res_o = a_i ^ b_i;
      OP_INC:  res_o = a_i + ONE;
      OP_DEC:  res_o = a_i - ONE;
      OP_PASS: res_o = b_i;
      default: res_o = a_i;
    endcase
  end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0]  a_i,
  input  logic [WIDTH-1:0]  b_i,
  input  logic [3:0]        op_i,
  input  logic [NFLAGS-1:0] flags_i,
  output logic [WIDTH-1:0]  res_o,
  output logic [NFLAGS-1:0] flags_o,
  output logic [NFLAGS-1:0] flag_we_o
);
  localparam int MSB = WIDTH - 1;

  alu_op_e op;
  assign op = alu_op_e'(op_i);

  logic             is_sub, is_cmp, is_shift;
  logic [WIDTH-1:0] as_sum, sh_res, lg_res;
  logic             as_cout, as_ovf, sh_cout;

  assign is_cmp   = (op == OP_CMP);
  assign is_sub   = (op == OP_SUB) || is_cmp;
  assign is_shift = (op == OP_SHL) || (op == OP_SHR) || (op == OP_ROL) || (op == OP_ROR);

  alu8_addsub #(.WIDTH(WIDTH)) u_addsub (
    .a_i    (a_i),
    .b_i    (b_i),
    .cin_i  (flags_i[FLAG_C]),
    .sub_i  (is_sub),
    .cmp_i  (is_cmp),
    .sum_o  (as_sum),
    .cout_o (as_cout),
    .ovf_o  (as_ovf)
  );

  alu8_shift #(.WIDTH(WIDTH)) u_shift (
    .a_i    (a_i),
    .cin_i  (flags_i[FLAG_C]),
    .left_i ((op == OP_SHL) || (op == OP_ROL)),
    .rot_i  ((op == OP_ROL) || (op == OP_ROR)),
    .res_o  (sh_res),
    .cout_o (sh_cout)
  );

  alu8_logic #(.WIDTH(WIDTH)) u_logic (
    .a_i   (a_i),
    .b_i   (b_i),
    .op_i  (op),
    .res_o (lg_res)
  );

  always_comb begin
    case (op)
      OP_ADD, OP_SUB:                   begin res_o = as_sum; flag_we_o = WE_ALL;  end
      OP_CMP:                           begin res_o = a_i;    flag_we_o = WE_NZC;  end
      OP_SHL, OP_SHR, OP_ROL, OP_ROR:   begin res_o = sh_res; flag_we_o = WE_NZC;  end
      OP_AND, OP_OR, OP_XOR,
      OP_INC, OP_DEC, OP_PASS:          begin res_o = lg_res; flag_we_o = WE_NZ;   end
      default:                          begin res_o = a_i;    flag_we_o = WE_NONE; end
    endcase
  end

  // compare derives N/Z from the discarded difference
  logic [WIDTH-1:0]  nz_src;
  logic [NFLAGS-1:0] flag_new;
  assign nz_src = is_cmp ? as_sum : res_o;

  always_comb begin
    flag_new         = '0;
    flag_new[FLAG_N] = nz_src[MSB];
    flag_new[FLAG_Z] = (nz_src == '0);
    flag_new[FLAG_V] = as_ovf;
    flag_new[FLAG_C] = is_shift ? sh_cout : as_cout;
  end

  for (genvar g = 0; g < NFLAGS; g++) begin : g_flag
    assign flags_o[g] = flag_we_o[g] ? flag_new[g] : flags_i[g];
  end

  always_comb begin
    for (int i = 0; i < NFLAGS; i++)
      if (!flag_we_o[i])
        a_r10_hold_flag: assert (flags_o[i] == flags_i[i]);
    if (flag_we_o[FLAG_V])
      a_r3_v_arith_only: assert (op == OP_ADD || op == OP_SUB);
    if (op == OP_CMP)
      a_r4_cmp_keeps_a: assert (res_o == a_i && flags_o[FLAG_V] == flags_i[FLAG_V]);
    if (op_i > 4'd12)
      a_r11_noop: assert (flag_we_o == '0 && res_o == a_i);
  end
endmodule

// File: tb/alu8_core_test.sv
module alu8_core_test;
  logic       clk = 1'b0;
  logic [7:0] a, b, res;
  logic [3:0] op, fin, fout, we;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  alu8_core uut (
    .a_i(a), .b_i(b), .op_i(op), .flags_i(fin),
    .res_o(res), .flags_o(fout), .flag_we_o(we)
  );

  task automatic run(input string req, input logic [3:0] o, input logic [7:0] av,
                     input logic [7:0] bv, input logic [3:0] f, input logic [7:0] er,
                     input logic [3:0] ef, input logic [3:0] ew);
    @(posedge clk);
    op = o; a = av; b = bv; fin = f;
    @(negedge clk);
    checks++;
    if (res !== er || fout !== ef || we !== ew) begin
      errors++;
      $display("FAIL %s op=%0d a=%h b=%h: got res=%h flags=%b we=%b, exp res=%h flags=%b we=%b",
               req, o, av, bv, res, fout, we, er, ef, ew);
    end
  endtask

  // flags {N,V,Z,C}
  task automatic t_idle_state();
    run("R9", 4'd12, 8'h55, 8'h00, 4'b1000, 8'h00, 4'b0010, 4'b1010);
  endtask

  task automatic t_add();
    run("R1", 4'd0, 8'hFF, 8'h01, 4'b0000, 8'h00, 4'b0011, 4'b1111);
    run("R3", 4'd0, 8'h50, 8'h50, 4'b0000, 8'hA0, 4'b1100, 4'b1111);
    run("R3", 4'd0, 8'h7F, 8'h00, 4'b0001, 8'h80, 4'b1100, 4'b1111);
  endtask

  task automatic t_sub();
    run("R2", 4'd1, 8'h05, 8'h05, 4'b0001, 8'h00, 4'b0011, 4'b1111);
    run("R2", 4'd1, 8'h05, 8'h05, 4'b0000, 8'hFF, 4'b1000, 4'b1111);
    run("R3", 4'd1, 8'h50, 8'hB0, 4'b0001, 8'hA0, 4'b1100, 4'b1111);
  endtask

  task automatic t_arith_sweep();
    for (int i = 0; i < 400; i++) begin
      logic [7:0] x, y, r, yy;
      logic [8:0] s;
      logic cin, sb, vv;
      x = 8'((i * 37) ^ (i >> 2)); y = 8'(i * 91 + 13); cin = i[0]; sb = i[1];
      yy = sb ? ~y : y;
      s = {1'b0, x} + {1'b0, yy} + {8'd0, cin};
      r = s[7:0];
      vv = ((x[7] == yy[7]) && (r[7] != x[7]));
      run(sb ? "R2" : "R1", sb ? 4'd1 : 4'd0, x, y, {3'b000, cin}, r,
          {r[7], vv, r == 8'h00, s[8]}, 4'b1111);
    end
  endtask

  task automatic t_cmp();
    run("R4", 4'd2, 8'h40, 8'h40, 4'b0100, 8'h40, 4'b0111, 4'b1011);
    run("R4", 4'd2, 8'h10, 8'h20, 4'b0001, 8'h10, 4'b1000, 4'b1011);
    run("R4", 4'd2, 8'h00, 8'hFF, 4'b0000, 8'h00, 4'b0000, 4'b1011);
  endtask

  task automatic t_logic();
    run("R5", 4'd3, 8'hF0, 8'h3C, 4'b0101, 8'h30, 4'b0101, 4'b1010);
    run("R5", 4'd4, 8'h80, 8'h01, 4'b0000, 8'h81, 4'b1000, 4'b1010);
    run("R5", 4'd5, 8'hAA, 8'hAA, 4'b0000, 8'h00, 4'b0010, 4'b1010);
  endtask

  task automatic t_shift();
    run("R6", 4'd6, 8'h81, 8'h00, 4'b0100, 8'h02, 4'b0101, 4'b1011);
    run("R6", 4'd7, 8'h01, 8'h00, 4'b1000, 8'h00, 4'b0011, 4'b1011);
    run("R6", 4'd7, 8'h80, 8'h00, 4'b0001, 8'h40, 4'b0000, 4'b1011);
  endtask

  task automatic t_rotate();
    run("R7", 4'd8, 8'h80, 8'h00, 4'b0001, 8'h01, 4'b0001, 4'b1011);
    run("R7", 4'd9, 8'h01, 8'h00, 4'b0001, 8'h80, 4'b1001, 4'b1011);
    run("R7", 4'd9, 8'h02, 8'h00, 4'b0000, 8'h01, 4'b0000, 4'b1011);
  endtask

  task automatic t_incdec();
    run("R8", 4'd10, 8'hFF, 8'h00, 4'b0101, 8'h00, 4'b0111, 4'b1010);
    run("R8", 4'd11, 8'h00, 8'h00, 4'b0000, 8'hFF, 4'b1000, 4'b1010);
  endtask

  task automatic t_pass();
    run("R9", 4'd12, 8'h00, 8'h9C, 4'b0011, 8'h9C, 4'b1001, 4'b1010);
  endtask

  task automatic t_unused();
    run("R11", 4'd13, 8'h3C, 8'hFF, 4'b1010, 8'h3C, 4'b1010, 4'b0000);
    run("R11", 4'd15, 8'h00, 8'h01, 4'b0101, 8'h00, 4'b0101, 4'b0000);
  endtask

  // R10: every non-written flag must follow flags_i across all op codes
  task automatic t_hold();
    for (int o = 0; o < 16; o++) begin
      for (int f = 0; f < 16; f++) begin
        @(posedge clk);
        op = 4'(o); a = 8'h6B; b = 8'h2D; fin = 4'(f);
        @(negedge clk);
        checks++;
        if (((fout ^ fin) & ~we) != 4'b0000) begin
          errors++;
          $display("FAIL R10 op=%0d: got flags=%b, exp held bits of %b (we=%b)", o, fout, fin, we);
        end
      end
    end
  endtask

  initial begin
    a = '0; b = '0; op = 4'd12; fin = '0;
    t_idle_state();
    t_add();
    t_sub();
    t_arith_sweep();
    t_cmp();
    t_logic();
    t_shift();
    t_rotate();
    t_incdec();
    t_pass();
    t_unused();
    t_hold();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout, exp completion");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule